// File: doc/BRIEF.md
# Aliased Interrupt Mask Register Bank

This block holds the mask state for up to 64 maskable interrupt sources, organised as four 16-bit registers. A mask bit of 0 lets its interrupt be serviced. A mask bit of 1 blocks it. After reset every source is masked. Software reaches the bank through a small memory-mapped port, which accepts the following operations on each register:

- 16-bit halfword reads and writes.
- 8-bit reads and writes of either byte lane.
- Single-bit test, set and clear within a byte lane.

Each mask bit can also be reached through a second port. That port addresses one interrupt source by its number, in the way a per-source control register would be accessed. Both ports act on the same single flop per bit, so a change made through one port is seen at once through the other. The full mask state is sent to the interrupt priority logic as a flat 64-bit vector. The index of each source in that vector is the register number times 16 plus the bit position.

The top five bits of the last register have no source behind them. They always read as 1 and ignore writes from either port.

Top module: `imr_bank`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0xFFFF and `mask_vec` is all ones.
- R2: A halfword access (`bus_mode`=0) at offset 0x100 + 2·r reads or writes register r (r = 0..3). Bit b of register r drives `mask_vec[16·r+b]`. That output changes on the first rising clock edge after the write cycle and not before it.
- R3: A byte access (`bus_mode`=1) at an even address selects bits 7:0 of the register, and at an odd address selects bits 15:8. A byte write changes only that lane. A byte read returns the lane in `bus_rdata[7:0]`, with the upper byte zero.
- R4: `bus_mode`=2 sets bit `bus_bitsel` of the addressed byte lane, and `bus_mode`=3 clears it. All other bits are unchanged.
- R5: A read with `bus_mode`=2 or 3 returns the addressed bit in `bus_rdata[0]`, with all other bits zero.
- R6: Bits 15:11 of register 3 (sources 59..63) always read as 1. Writes to them from either port have no effect.
- R7: A write on the source port (`src_we`) sets the mask of source `src_idx` to `src_mask_in`. `src_mask_out` returns the mask of `src_idx`. Both ports read back the same stored bit.
- R8: If a bus write and a source-port write hit the same bit in one cycle, the source-port value is stored.
- R9: Addresses outside 0x100..0x107, and halfword accesses at odd addresses, read as zero and have no effect when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Bus read strobe; gates `bus_rdata` |
| bus_wr | input | 1 | Bus write strobe |
| bus_mode | input | 2 | 0 halfword, 1 byte, 2 bit set/test, 3 bit clear/test |
| bus_addr | input | 12 | Byte address |
| bus_bitsel | input | 3 | Bit position inside the addressed byte lane |
| bus_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 16 | Read data, combinational from the address |
| src_we | input | 1 | Source-port mask write |
| src_idx | input | 6 | Source number |
| src_mask_in | input | 1 | Mask value written through the source port |
| src_mask_out | output | 1 | Current mask of source `src_idx` |
| mask_vec | output | 64 | Flat mask vector for the priority logic |

## Verification
The bench first writes full halfwords with mixed patterns (0x1234, 0xA5A5, all zeros). It then reads the registers back as words, as bytes and as single bits. A wrong lane or wrong bit mapping gives a different value in each of these views. Byte writes and bit set/clear are applied to registers that hold known asymmetric contents, so any spill into the neighbouring lane or bit shows up. Accesses through the source port, and same-cycle collisions between the two ports, are read back through the bus. This separates "both views share one bit" from "the views merely agree". Writes to the fixed bits, to unmapped offsets and to odd halfword addresses are followed by reads that would expose any change.

// File: rtl/imr_pkg.sv
// Package: shared access-mode encoding for the interrupt mask bank.
// Assumes the bus presents a 2-bit mode code alongside each access.
package imr_pkg;
    typedef enum logic [1:0] {
        ACC_HALF = 2'd0,
        ACC_BYTE = 2'd1,
        ACC_BSET = 2'd2,
        ACC_BCLR = 2'd3
    } acc_mode_e;
endpackage

// File: rtl/imr_bus_decode.sv
// Module: imr_bus_decode
// Turns one bus access into per-bit write enables and write values over
// the whole flat mask vector, and reports which register and lane it hit.
// Assumes REG_W is two byte lanes wide and the registers sit at
// consecutive halfword offsets from BASE.
module imr_bus_decode
    import imr_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int BASE     = 'h100,
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 16,
    localparam int LANE_W  = REG_W / 2,
    localparam int BS_W    = $clog2(LANE_W),
    localparam int RSEL_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int TOTAL   = NUM_REGS * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BS_W-1:0]   bus_bitsel,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic              hit,
    output logic [RSEL_W-1:0] reg_sel,
    output logic              lane,
    output logic [TOTAL-1:0]  wr_en,
    output logic [TOTAL-1:0]  wr_val
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(2 * NUM_REGS);

    acc_mode_e        mode;
    logic [ADDR_W-1:0] off;
    logic              in_range;

    // Offset arithmetic and mapped-window test.
    always_comb begin
        mode     = acc_mode_e'(bus_mode);
        off      = bus_addr - BASE_A;
        in_range = (bus_addr >= BASE_A) && (off < SPAN_A);
        reg_sel  = off[RSEL_W:1];
        lane     = off[0];
        hit      = in_range && !((mode == ACC_HALF) && off[0]);
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar b = 0; b < REG_W; b++) begin : g_bit
            localparam int IDX = r * REG_W + b;
            localparam int LN  = b / LANE_W;
            localparam int POS = b % LANE_W;
            logic sel;
            logic lane_ok;
            // Per-bit enable and value for this access.
            always_comb begin
                sel     = hit && (reg_sel == RSEL_W'(r));
                lane_ok = (lane == 1'(LN));
                unique case (mode)
                    ACC_HALF: begin
                        wr_en[IDX]  = bus_wr && sel;
                        wr_val[IDX] = bus_wdata[b];
                    end
                    ACC_BYTE: begin
                        wr_en[IDX]  = bus_wr && sel && lane_ok;
                        wr_val[IDX] = bus_wdata[POS];
                    end
                    ACC_BSET: begin
                        wr_en[IDX]  = bus_wr && sel && lane_ok && (bus_bitsel == BS_W'(POS));
                        wr_val[IDX] = 1'b1;
                    end
                    default: begin
                        wr_en[IDX]  = bus_wr && sel && lane_ok && (bus_bitsel == BS_W'(POS));
                        wr_val[IDX] = 1'b0;
                    end
                endcase
            end
        end
    end

    // R4
    single_bit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode[1]) |-> ($countones(wr_en) <= 1));

endmodule

// File: rtl/imr_src_decode.sv
// Module: imr_src_decode
// Decodes the per-source control port into a one-hot write enable over
// the flat mask vector. Sources at or above NUM_SRC have no storage and
// never receive an enable.
module imr_src_decode #(
    parameter int TOTAL   = 64,
    parameter int NUM_SRC = 59,
    localparam int IDX_W  = $clog2(TOTAL)
) (
    input  logic             src_we,
    input  logic [IDX_W-1:0] src_idx,
    input  logic             src_mask_in,
    output logic [TOTAL-1:0] wr_en,
    output logic [TOTAL-1:0] wr_val
);
    for (genvar i = 0; i < TOTAL; i++) begin : g_src
        if (i < NUM_SRC) begin : g_live
            // Enable only the addressed live source.
            assign wr_en[i] = src_we && (src_idx == IDX_W'(i));
        end else begin : g_none
            assign wr_en[i] = 1'b0;
        end
        assign wr_val[i] = src_mask_in;
    end
endmodule

// File: rtl/imr_store.sv
// Module: imr_store
// One flop per live mask bit, shared by both register views. The
// source-port write outranks a bus write to the same bit. Bits at or
// above NUM_SRC are tied to one and keep no state.
module imr_store #(
    parameter int TOTAL   = 64,
    parameter int NUM_SRC = 59
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOTAL-1:0] bus_en,
    input  logic [TOTAL-1:0] bus_val,
    input  logic [TOTAL-1:0] src_en,
    input  logic [TOTAL-1:0] src_val,
    output logic [TOTAL-1:0] mask_q
);
    for (genvar i = 0; i < TOTAL; i++) begin : g_bit
        if (i < NUM_SRC) begin : g_live
            logic bit_q;
            // Storage flop: reset masked, source port wins a collision.
            always_ff @(posedge clk) begin
                if (!rst_n)          bit_q <= 1'b1;
                else if (src_en[i])  bit_q <= src_val[i];
                else if (bus_en[i])  bit_q <= bus_val[i];
            end
            assign mask_q[i] = bit_q;

            // R8
            src_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (src_en[i] && bus_en[i]) |=> (mask_q[i] == $past(src_val[i])));
        end else begin : g_fixed
            logic unused_inputs;
            assign unused_inputs = ^{bus_en[i], bus_val[i], src_en[i], src_val[i]};
            assign mask_q[i]     = 1'b1;
        end
    end

    // R1
    reset_all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (&mask_q));
endmodule

// File: rtl/imr_read_mux.sv
// Module: imr_read_mux
// Builds bus read data from the mask vector for halfword, byte and
// single-bit reads. Returns zero when no read is strobed or the access
// misses the mapped window.
module imr_read_mux
    import imr_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 16,
    localparam int LANE_W  = REG_W / 2,
    localparam int BS_W    = $clog2(LANE_W),
    localparam int RSEL_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int TOTAL   = NUM_REGS * REG_W
) (
    input  logic              rd,
    input  logic              hit,
    input  logic [RSEL_W-1:0] reg_sel,
    input  logic              lane,
    input  logic [1:0]        mode,
    input  logic [BS_W-1:0]   bitsel,
    input  logic [TOTAL-1:0]  mask_vec,
    output logic [REG_W-1:0]  rdata
);
    logic [REG_W-1:0]  word;
    logic [LANE_W-1:0] byte_v;

    // Select word, lane and bit for the read.
    always_comb begin
        word   = mask_vec[int'(reg_sel) * REG_W +: REG_W];
        byte_v = lane ? word[REG_W-1:LANE_W] : word[LANE_W-1:0];
        rdata  = '0;
        if (rd && hit) begin
            unique case (acc_mode_e'(mode))
                ACC_HALF: rdata = word;
                ACC_BYTE: rdata = REG_W'(byte_v);
                default:  rdata = REG_W'(byte_v[bitsel]);
            endcase
        end
    end
endmodule

// File: rtl/imr_bank.sv
// Module: imr_bank (top)
// Interrupt mask bank with a packed-register bus view and a per-source
// view over shared storage, plus a flat mask vector for priority logic.
// Assumes a single clock and synchronous active-low reset.
module imr_bank #(
    parameter int ADDR_W   = 12,
    parameter int BASE     = 'h100,
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 16,
    parameter int NUM_SRC  = 59,
    localparam int TOTAL   = NUM_REGS * REG_W,
    localparam int IDX_W   = $clog2(TOTAL),
    localparam int BS_W    = $clog2(REG_W / 2),
    localparam int RSEL_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BS_W-1:0]   bus_bitsel,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              src_we,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic              src_mask_in,
    output logic              src_mask_out,
    output logic [TOTAL-1:0]  mask_vec
);
    logic              bus_hit;
    logic [RSEL_W-1:0] reg_sel;
    logic              lane;
    logic [TOTAL-1:0]  bus_en, bus_val, src_en, src_val;

    imr_bus_decode #(
        .ADDR_W(ADDR_W), .BASE(BASE), .NUM_REGS(NUM_REGS), .REG_W(REG_W)
    ) u_bus_dec (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_mode(bus_mode),
        .bus_addr(bus_addr), .bus_bitsel(bus_bitsel), .bus_wdata(bus_wdata),
        .hit(bus_hit), .reg_sel(reg_sel), .lane(lane),
        .wr_en(bus_en), .wr_val(bus_val)
    );

    imr_src_decode #(.TOTAL(TOTAL), .NUM_SRC(NUM_SRC)) u_src_dec (
        .src_we(src_we), .src_idx(src_idx), .src_mask_in(src_mask_in),
        .wr_en(src_en), .wr_val(src_val)
    );

    imr_store #(.TOTAL(TOTAL), .NUM_SRC(NUM_SRC)) u_store (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_val(bus_val),
        .src_en(src_en), .src_val(src_val), .mask_q(mask_vec)
    );

    imr_read_mux #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_rd_mux (
        .rd(bus_rd), .hit(bus_hit), .reg_sel(reg_sel), .lane(lane),
        .mode(bus_mode), .bitsel(bus_bitsel), .mask_vec(mask_vec),
        .rdata(bus_rdata)
    );

    // Per-source view reads the shared storage directly.
    assign src_mask_out = mask_vec[src_idx];

    // R7
    src_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_we && (src_idx < IDX_W'(NUM_SRC))) |=> (mask_vec[$past(src_idx)] == $past(src_mask_in)));

    // R9
    unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_hit && !src_we) |=> $stable(mask_vec));

    // R6
    fixed_ones_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_idx >= IDX_W'(NUM_SRC)) |-> src_mask_out);
endmodule

// File: tb/imr_bank_bench.sv
module imr_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_mode = 2'd0;
    logic [11:0] bus_addr = 12'h0;
    logic [2:0]  bus_bitsel = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        src_we = 1'b0;
    logic [5:0]  src_idx = 6'd0;
    logic        src_mask_in = 1'b0;
    logic        src_mask_out;
    logic [63:0] mask_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    imr_bank u_imr_bank (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_mode(bus_mode), .bus_addr(bus_addr), .bus_bitsel(bus_bitsel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_we(src_we),
        .src_idx(src_idx), .src_mask_in(src_mask_in),
        .src_mask_out(src_mask_out), .mask_vec(mask_vec)
    );

    typedef struct {
        string       req;
        logic [15:0] rd;
        logic        so;
        logic [63:0] vec;
    } item_t;

    item_t       sb_q[$];
    event        sample_ev;
    int          n_checks = 0;
    int          n_errors = 0;
    logic [63:0] model = '1;

    // Expected read data from the requirement rules R2, R3, R5, R9.
    function automatic logic [15:0] exp_read(logic rd, logic [11:0] a, logic [1:0] m, logic [2:0] bs);
        logic [11:0] off;
        logic [15:0] w;
        int r;
        if (!rd || a < 12'h100 || a > 12'h107) return 16'h0;
        off = a - 12'h100;
        r   = int'(off[2:1]);
        w   = model[r*16 +: 16];
        case (m)
            2'd0:    return off[0] ? 16'h0 : w;
            2'd1:    return {8'h0, off[0] ? w[15:8] : w[7:0]};
            default: return {15'h0, w[int'(off[0])*8 + int'(bs)]};
        endcase
    endfunction

    function automatic void apply_bus(logic [11:0] a, logic [1:0] m, logic [2:0] bs, logic [15:0] d);
        logic [11:0] off;
        int r;
        if (a < 12'h100 || a > 12'h107) return;
        off = a - 12'h100;
        if (m == 2'd0 && off[0]) return;
        r = int'(off[2:1]);
        for (int b = 0; b < 16; b++) begin
            int idx = r*16 + b;
            if (idx >= 59) continue;
            case (m)
                2'd0: model[idx] = d[b];
                2'd1: if ((b/8) == int'(off[0])) model[idx] = d[b%8];
                2'd2: if ((b/8) == int'(off[0]) && (b%8) == int'(bs)) model[idx] = 1'b1;
                default: if ((b/8) == int'(off[0]) && (b%8) == int'(bs)) model[idx] = 1'b0;
            endcase
        end
    endfunction

    function automatic void apply_src(logic [5:0] idx, logic v);
        if (idx < 6'd59) model[idx] = v;
    endfunction

    // Driver side: push the expected item and wake the monitor.
    task automatic sample(string req);
        item_t it;
        it.req = req;
        it.rd  = exp_read(bus_rd, bus_addr, bus_mode, bus_bitsel);
        it.so  = model[src_idx];
        it.vec = model;
        sb_q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    // Monitor: pop and compare against the outputs.
    initial begin
        forever begin
            item_t it;
            @(sample_ev);
            it = sb_q.pop_front();
            n_checks += 3;
            if (bus_rdata !== it.rd) begin
                n_errors++;
                $display("FAIL %s rdata actual=%h expected=%h", it.req, bus_rdata, it.rd);
            end
            if (src_mask_out !== it.so) begin
                n_errors++;
                $display("FAIL %s src_mask_out actual=%b expected=%b", it.req, src_mask_out, it.so);
            end
            if (mask_vec !== it.vec) begin
                n_errors++;
                $display("FAIL %s mask_vec actual=%h expected=%h", it.req, mask_vec, it.vec);
            end
        end
    end

    task automatic check_read(string req, logic [11:0] a, logic [1:0] m, logic [2:0] bs, logic [5:0] sidx);
        @(negedge clk);
        bus_wr = 1'b0; src_we = 1'b0; bus_rd = 1'b1;
        bus_addr = a; bus_mode = m; bus_bitsel = bs; src_idx = sidx;
        #(CLK_PERIOD/4);
        sample(req);
    endtask

    task automatic bus_write(logic [11:0] a, logic [1:0] m, logic [2:0] bs, logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b0; src_we = 1'b0; bus_wr = 1'b1;
        bus_addr = a; bus_mode = m; bus_bitsel = bs; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        apply_bus(a, m, bs, d);
    endtask

    task automatic src_write(logic [5:0] idx, logic v);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; src_we = 1'b1; src_idx = idx; src_mask_in = v;
        @(negedge clk);
        src_we = 1'b0;
        apply_src(idx, v);
    endtask

    task automatic both_write(logic [11:0] a, logic [15:0] d, logic [5:0] idx, logic v);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_mode = 2'd0; bus_wdata = d;
        src_we = 1'b1; src_idx = idx; src_mask_in = v;
        @(negedge clk);
        bus_wr = 1'b0; src_we = 1'b0;
        apply_bus(a, 2'd0, 3'd0, d);
        apply_src(idx, v);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every register
        for (int r = 0; r < 4; r++) check_read("R1", 12'(12'h100 + 2*r), 2'd0, 3'd0, 6'(r));

        // R2: halfword writes with mixed patterns
        bus_write(12'h100, 2'd0, 3'd0, 16'h1234);
        bus_write(12'h102, 2'd0, 3'd0, 16'hA5A5);
        check_read("R2", 12'h100, 2'd0, 3'd0, 6'd2);
        check_read("R2", 12'h102, 2'd0, 3'd0, 6'd16);
        // R6: zero written to register 3, top five bits stay one
        bus_write(12'h106, 2'd0, 3'd0, 16'h0000);
        check_read("R6", 12'h106, 2'd0, 3'd0, 6'd60);

        // R3: byte write to upper lane of register 1, then byte reads
        bus_write(12'h103, 2'd1, 3'd0, 16'h003C);
        check_read("R3", 12'h102, 2'd0, 3'd0, 6'd26);
        check_read("R3", 12'h102, 2'd1, 3'd0, 6'd0);
        check_read("R3", 12'h103, 2'd1, 3'd0, 6'd0);
        bus_write(12'h100, 2'd1, 3'd0, 16'hFF00);
        check_read("R3", 12'h100, 2'd0, 3'd0, 6'd1);

        // R4: bit set and clear
        bus_write(12'h100, 2'd2, 3'd3, 16'h0000);
        bus_write(12'h105, 2'd3, 3'd7, 16'hFFFF);
        check_read("R4", 12'h100, 2'd0, 3'd0, 6'd3);
        check_read("R4", 12'h104, 2'd0, 3'd0, 6'd47);
        // R5: bit tests
        check_read("R5", 12'h105, 2'd2, 3'd7, 6'd0);
        check_read("R5", 12'h101, 2'd3, 3'd4, 6'd0);
        check_read("R5", 12'h100, 2'd2, 3'd3, 6'd0);

        // R7: source port write, seen through the bus view
        src_write(6'd20, 1'b0);
        check_read("R7", 12'h102, 2'd0, 3'd0, 6'd20);
        bus_write(12'h104, 2'd2, 3'd1, 16'h0);
        check_read("R7", 12'h104, 2'd1, 3'd0, 6'd33);
        // R6: source port write to a fixed bit and a bus bit clear
        src_write(6'd59, 1'b0);
        bus_write(12'h107, 2'd3, 3'd5, 16'h0);
        check_read("R6", 12'h106, 2'd0, 3'd0, 6'd59);

        // R8: collision, source value wins on bit 33
        both_write(12'h104, 16'h0000, 6'd33, 1'b1);
        check_read("R8", 12'h104, 2'd0, 3'd0, 6'd33);
        both_write(12'h104, 16'hFFFF, 6'd40, 1'b0);
        check_read("R8", 12'h104, 2'd0, 3'd0, 6'd40);

        // R9: unmapped and odd halfword accesses
        bus_write(12'h108, 2'd0, 3'd0, 16'h0000);
        bus_write(12'h101, 2'd0, 3'd0, 16'h0000);
        bus_write(12'h0FF, 2'd1, 3'd0, 16'h0000);
        check_read("R9", 12'h108, 2'd0, 3'd0, 6'd8);
        check_read("R9", 12'h0FE, 2'd0, 3'd0, 6'd8);
        check_read("R9", 12'h101, 2'd0, 3'd0, 6'd8);

        // R2: output unchanged before the edge, updated after it
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = 12'h106; bus_mode = 2'd0; bus_wdata = 16'h0001;
        #(CLK_PERIOD/4);
        sample("R2");
        @(negedge clk);
        bus_wr = 1'b0;
        apply_bus(12'h106, 2'd0, 3'd0, 16'h0001);
        #(CLK_PERIOD/4);
        sample("R2");

        // R1: reset again restores all masks
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model = '1;
        check_read("R1", 12'h104, 2'd0, 3'd0, 6'd33);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule